// File: doc/BRIEF.md
# Aperture Remapper Control Sequencer

This block drives the control register of a graphics aperture remapper through the fixed multi-write patterns the remapper needs. A requester asks for one of three operations on a request/acknowledge port: flush the translation state, bring the aperture up, or take it down. The sequencer then produces one control-register write per step on a write port that has a ready input.

Bringing the aperture up takes two flush patterns with a handshake to an external agent between them. That agent writes the graphics command register, which lies outside this block. Taking the aperture down first waits for the remapper's idle status. If idle does not arrive within a programmable number of cycles, the sequencer gives up with an error pulse and leaves the aperture enabled.

Top module: `aperture_seq`

## Requirements
- R1: After reset, busy, wr_valid, cmdreg_req, err and cmd_ack (with cmd_req low) are all low.
- R2: Every written word uses only three bits: bit 0 = invalidate, bit 8 = enable, bit 16 = double-rate reset. All other bits are zero.
- R3: Operation code 0 (flush) writes 0x00000101, 0x00000100, 0x00010100, 0x00000100, in that order.
- R4: Operation code 1 (bring up) writes the R3 pattern and then holds cmdreg_req high, with no writes, until cmdreg_ack is seen. It then writes the R3 pattern a second time, for 8 writes in total.
- R5: Operation code 2 (take down) issues no write while idle_in is low. Once idle_in is high it writes 0x00000101, 0x00000000, 0x00010000, 0x00000000.
- R6: wr_valid is high only in a cycle where wr_ready is high. Each high cycle is exactly one write, and a low wr_ready stalls the pattern without losing a step.
- R7: busy rises in the cycle after the accepting edge and stays high through the cycle of the final write (or error). It is low in the cycle after that.
- R8: cmd_ack is high, in the same cycle, exactly when cmd_req is high, busy is low and cmd_op is not 3. A request while busy, or with code 3, is not acknowledged and causes no write.
- R9: During take-down, if idle_in has stayed low for timeout_cfg+1 waiting cycles, err pulses for one cycle in the last of them, no write is issued, and busy falls in the next cycle. timeout_cfg must stay stable while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Operation request |
| cmd_op | input | 2 | Operation code: 0 flush, 1 bring up, 2 take down, 3 reserved |
| cmd_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Operation in progress |
| timeout_cfg | input | 16 | Idle-wait limit in cycles |
| idle_in | input | 1 | Remapper reports idle |
| wr_ready | input | 1 | Register write port can take a write |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_data | output | 32 | Control word being written |
| cmdreg_req | output | 1 | Ask external agent to write the command register |
| cmdreg_ack | input | 1 | External command-register write done |
| err | output | 1 | Idle wait timed out |

## Verification
The bench throttles wr_ready at random so that each pattern has to survive stalls. A design that advanced its step counter on a stalled cycle would skip or repeat a word. It delays cmdreg_ack so that any write leaking out during the handshake, or a second flush starting early, shows up in the logged order. It tries timeout limits of 0 and 5 with idle held low, which would expose an off-by-one in the wait counter or a shutdown that writes anyway. It also sends requests while busy and with the reserved code, and a sequencer that acknowledged either would restart or append writes.

// File: rtl/aperture_seq_pkg.sv
package aperture_seq_pkg;

  localparam int CTL_W   = 32;
  localparam int SEQ_LEN = 4;
  localparam int SEQ_W   = $clog2(SEQ_LEN);
  localparam int TO_W    = 16;

  localparam int BIT_INV = 0;
  localparam int BIT_EN  = 8;
  localparam int BIT_RST = 16;

  localparam logic [CTL_W-1:0] CTL_MASK =
    (CTL_W'(1) << BIT_INV) | (CTL_W'(1) << BIT_EN) | (CTL_W'(1) << BIT_RST);

  typedef enum logic [1:0] {
    OP_FLUSH = 2'd0,
    OP_UP    = 2'd1,
    OP_DOWN  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_WR,
    S_CMD
  } st_e;

  typedef enum logic {
    PAT_FLUSH,
    PAT_SHUT
  } pat_e;

  // Control word for one step of a four-write pattern.
  function automatic logic [CTL_W-1:0] ctl_word(pat_e pat, logic [SEQ_W-1:0] step);
    logic [CTL_W-1:0] w;
    w = '0;
    w[BIT_INV] = (step == SEQ_W'(0));
    w[BIT_RST] = (step == SEQ_W'(2));
    w[BIT_EN]  = (pat == PAT_FLUSH) || (step == SEQ_W'(0));
    return w;
  endfunction

endpackage

// File: rtl/aps_step_ctr.sv
module aps_step_ctr #(
  parameter int LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   adv,
  output logic [$clog2(LEN)-1:0] step,
  output logic                   last
);
  localparam int W = $clog2(LEN);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)            step <= '0;
    else if (adv && !last)        step <= step + 1'b1;
    else if (adv)                 step <= '0;
  end

  assign last = (step == W'(LEN - 1));

endmodule

// File: rtl/aps_wait_timer.sv
module aps_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = active && tick && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !active)        cnt <= '0;
    else if (tick && !expired)    cnt <= cnt + 1'b1;
  end

  // R9: waiting count never passes the limit
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= limit));

endmodule

// File: rtl/aperture_seq.sv
module aperture_seq
  import aperture_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_req,
  input  logic [1:0]        cmd_op,
  output logic              cmd_ack,
  output logic              busy,
  input  logic [TO_W-1:0]   timeout_cfg,
  input  logic              idle_in,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [CTL_W-1:0]  wr_data,
  output logic              cmdreg_req,
  input  logic              cmdreg_ack,
  output logic              err
);
  st_e  st, st_nx;
  pat_e pat_q;
  logic more_q;

  logic [SEQ_W-1:0] step;
  logic             step_last;
  logic             accept, wr_fire, seq_end, wait_tick, expired, cmd_done;
  op_e              op;

  assign op        = op_e'(cmd_op);
  assign accept    = cmd_req && (st == S_IDLE) && (op != OP_RSVD);
  assign wr_fire   = (st == S_WR) && wr_ready;
  assign seq_end   = wr_fire && step_last;
  assign wait_tick = (st == S_WAIT) && !idle_in;
  assign cmd_done  = (st == S_CMD) && cmdreg_ack;

  assign cmd_ack    = accept;
  assign busy       = (st != S_IDLE);
  assign wr_valid   = wr_fire;
  assign wr_data    = ctl_word(pat_q, step);
  assign cmdreg_req = (st == S_CMD);
  assign err        = expired;

  aps_step_ctr #(.LEN(SEQ_LEN)) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st != S_WR),
    .adv  (wr_fire),
    .step (step),
    .last (step_last)
  );

  aps_wait_timer #(.W(TO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (st == S_WAIT),
    .tick   (wait_tick),
    .limit  (timeout_cfg),
    .expired(expired)
  );

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (accept) st_nx = (op == OP_DOWN) ? S_WAIT : S_WR;
      S_WAIT: if (idle_in) st_nx = S_WR;
              else if (expired) st_nx = S_IDLE;
      S_WR:   if (seq_end) st_nx = more_q ? S_CMD : S_IDLE;
      S_CMD:  if (cmd_done) st_nx = S_WR;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pat_q  <= PAT_FLUSH;
      more_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        pat_q  <= (op == OP_DOWN) ? PAT_SHUT : PAT_FLUSH;
        more_q <= (op == OP_UP);
      end else if (seq_end) begin
        more_q <= 1'b0;
      end
    end
  end

  assert_wr_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready);

  assert_data_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & ~CTL_MASK) == '0));

  assert_ack_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> !busy);

  assert_ack_then_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> busy);

  assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid);

  assert_err_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !busy);

  assert_cmdreg_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdreg_req) |-> $past(wr_valid));

  assert_cmdreg_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmdreg_req |-> !wr_valid);

endmodule

// File: tb/aperture_seq_tb.sv
module aperture_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_req = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_ack, busy, wr_valid, cmdreg_req, err;
  logic [15:0] timeout_cfg = 16'd30;
  logic        idle_in = 1'b0;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_data;
  logic        cmdreg_ack = 1'b0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  aperture_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op),
    .cmd_ack(cmd_ack), .busy(busy), .timeout_cfg(timeout_cfg),
    .idle_in(idle_in), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_data(wr_data), .cmdreg_req(cmdreg_req), .cmdreg_ack(cmdreg_ack),
    .err(err)
  );

  // stimulus controls
  int rdy_mode = 0;      // 0 always ready, 1 random, 2 held low
  int idle_delay = 0;
  int busy_run = 0;
  bit ack_en = 1'b1;

  always @(posedge clk) begin
    #1;
    busy_run = busy ? busy_run + 1 : 0;
    idle_in  = (busy_run >= idle_delay);
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = ($urandom % 4) != 0;
      default: wr_ready = 1'b0;
    endcase
    cmdreg_ack = ack_en && cmdreg_req && (($urandom % 3) == 0);
  end

  // observation log
  logic [31:0] wlog [0:63];
  int nw, cmd_pos, cyc, last_wr_cyc, fall_cyc, bad_ready, bad_cmd;
  int err_seen, err_busy, busy_cycles;
  logic prev_busy = 1'b0;

  task automatic clear_log();
    nw = 0; cmd_pos = -1; last_wr_cyc = -1; fall_cyc = -1;
    bad_ready = 0; bad_cmd = 0; err_seen = 0; err_busy = 0; busy_cycles = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (wr_valid) begin
      if (nw < 64) wlog[nw] = wr_data;
      nw++;
      last_wr_cyc = cyc;
      if (!wr_ready) bad_ready++;
      if (cmdreg_req) bad_cmd++;
    end
    if (cmdreg_req && cmdreg_ack) cmd_pos = nw;
    if (prev_busy && !busy) fall_cyc = cyc;
    prev_busy = busy;
    if (busy) busy_cycles++;
    if (err) begin err_seen++; err_busy = busy_cycles; end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int op, int i);
    int k = i % 4;
    if (op == 2) return (k == 0) ? 32'h0000_0101 : (k == 2) ? 32'h0001_0000 : 32'h0;
    return (k == 0) ? 32'h0000_0101 : (k == 2) ? 32'h0001_0100 : 32'h0000_0100;
  endfunction

  function automatic int exp_count(int op);
    return (op == 1) ? 8 : 4;
  endfunction

  task automatic wait_free();
    int guard = 0;
    do begin
      @(negedge clk); #1;
      guard++;
    end while (busy && guard < 5000);
    chk(!busy, "R7 busy ends", busy, 0);
  endtask

  task automatic issue(int op, bit exp_ack);
    @(posedge clk); #1;
    cmd_req = 1'b1; cmd_op = 2'(op);
    @(negedge clk); #1;
    chk(cmd_ack == exp_ack, "R8 cmd_ack", cmd_ack, exp_ack);
    @(posedge clk); #1;
    cmd_req = 1'b0;
  endtask

  task automatic check_seq(int op);
    string rq = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
    chk(nw == exp_count(op), {rq, " write count"}, nw, exp_count(op));
    for (int i = 0; i < exp_count(op) && i < nw; i++)
      chk(wlog[i] == exp_word(op, i), {rq, " R2 word"}, wlog[i], exp_word(op, i));
    chk(fall_cyc == last_wr_cyc + 1, "R7 busy fall after last write", fall_cyc, last_wr_cyc + 1);
    chk(bad_ready == 0, "R6 write without ready", bad_ready, 0);
    if (op == 1) begin
      chk(cmd_pos == 4, "R4 command write between flushes", cmd_pos, 4);
      chk(bad_cmd == 0, "R4 write during handshake", bad_cmd, 0);
    end
    chk(err_seen == 0, "R9 no error", err_seen, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_log();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!busy && !wr_valid && !cmdreg_req && !err && !cmd_ack, "R1 reset outputs",
        {busy, wr_valid, cmdreg_req, err, cmd_ack}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !wr_valid && !cmdreg_req && !err, "R1 after reset",
        {busy, wr_valid, cmdreg_req, err}, 0);

    // directed: each operation with ready held high
    for (int op = 0; op < 3; op++) begin
      clear_log(); rdy_mode = 0; idle_delay = 3;
      issue(op, 1'b1);
      wait_free();
      check_seq(op);
    end

    // R8: reserved code refused
    clear_log();
    issue(3, 1'b0);
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && nw == 0, "R8 reserved code no effect", nw, 0);

    // R8/R6: request during a stalled flush is refused
    clear_log(); rdy_mode = 2;
    issue(0, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk(nw == 0 && busy, "R6 stall holds writes", nw, 0);
    issue(2, 1'b0);
    rdy_mode = 0;
    wait_free();
    check_seq(0);

    // R9: timeouts of 5 and 0 with idle never reported
    for (int t = 0; t < 2; t++) begin
      int lim = (t == 0) ? 5 : 0;
      clear_log(); idle_delay = 100000; timeout_cfg = 16'(lim);
      issue(2, 1'b1);
      wait_free();
      chk(err_seen == 1, "R9 one error pulse", err_seen, 1);
      chk(err_busy == lim + 1, "R9 wait length", err_busy, lim + 1);
      chk(nw == 0, "R9 no write on timeout", nw, 0);
      chk(fall_cyc > 0, "R9 busy drops", fall_cyc, 1);
    end

    // R5: idle arrives after several cycles, writes wait for it
    clear_log(); idle_delay = 7; timeout_cfg = 16'd20;
    issue(2, 1'b1);
    wait_free();
    check_seq(2);

    // random mix
    for (int n = 0; n < 24; n++) begin
      int op = $urandom % 3;
      clear_log();
      rdy_mode = $urandom % 2;
      idle_delay = $urandom % 8;
      timeout_cfg = 16'(20 + $urandom % 20);
      issue(op, 1'b1);
      wait_free();
      check_seq(op);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule